// File: doc/BRIEF.md
# Stereo Attenuator Mute and Power-Up Controller

This block is the digital sequencer for a stereo volume attenuator. It owns the volume code that is applied to both channels, the enable that connects the output buffers to the pins, and the start strobe for the external offset-calibration circuit. A load strobe writes a new 8-bit code, and a code of zero is the software mute. A soft-mute request walks the code down to zero one step per step period.

Hardware mute comes from an active-low pin or from a supply-undervoltage flag. The disconnect is held back until both channels report a zero crossing in the same cycle, or until an 18 ms timeout, whichever comes first. Every disconnect requests one calibration, and the outputs reconnect only after the calibration has reported done. After reset, and again after the supply recovers from an undervoltage event, the block clears the volume, refuses writes for a 100 us window, runs a calibration and then returns to normal operation. The current controller state is brought out on a status port.

Top module: `audio_mute_seq`

## Requirements
- R1: During the power-on window (`state_o` = 0), `wr_ignored` is 1, `vol_code` is 0, `out_connect` is 0, and a load has no effect. The window lasts POR_CYC+1 cycles after reset release, where POR_CYC = CLK_HZ/10000.
- R2: At the end of the window the state becomes CALIBRATE (1) with a one-cycle `cal_start`. It stays there with the outputs disconnected until a `cal_done` pulse has been registered while `mute_n` is 1. It then moves to ACTIVE (2) with `out_connect` = 1.
- R3: In ACTIVE, a load sets `vol_code` to `load_code` on the next cycle. Loading 0 leaves `out_connect` at 1.
- R4: A soft-mute request in ACTIVE with a nonzero code enters SOFT_RAMP (5). The code then falls by one every STEP_CYC cycles and the state returns to ACTIVE when it reaches 0. A request while the code is 0 leaves the state at ACTIVE.
- R5: A load during SOFT_RAMP ends the ramp, takes the loaded code and returns to ACTIVE.
- R6: `mute_n` = 0 in ACTIVE enters MUTE_PENDING (3) with the outputs still connected. A zero-crossing flag on one channel alone does nothing. With both flags high in the same cycle, the next cycle is MUTED (4) with `out_connect` = 0.
- R7: Without zero crossings, MUTE_PENDING lasts exactly TMO_CYC+1 cycles before MUTED, where TMO_CYC = CLK_HZ*18/1000.
- R8: Each entry into MUTED, and each entry into CALIBRATE, gives a `cal_start` pulse of exactly one cycle. In MUTED it coincides with the fall of `out_connect`.
- R9: MUTED holds the volume register and still accepts loads. It returns to ACTIVE only when `mute_n` = 1 and a `cal_done` pulse has been registered since the last `cal_start`.
- R10: `uv_flag` = 1 in ACTIVE takes the hardware-mute path. MUTED is held while the flag stays high, even after calibration. When the flag clears, the state goes to the power-on window with `vol_code` = 0.
- R11: `uv_flag` held high keeps the power-on window open. `uv_flag` during CALIBRATE returns the state to the power-on window.
- R12: `state_o` encodes the state as 0 power-on window, 1 CALIBRATE, 2 ACTIVE, 3 MUTE_PENDING, 4 MUTED, 5 SOFT_RAMP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on reset) |
| mute_n | input | 1 | Active-low hardware mute pin |
| zc_left | input | 1 | Left channel zero-crossing flag |
| zc_right | input | 1 | Right channel zero-crossing flag |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| load_strobe | input | 1 | Volume register write strobe |
| load_code | input | VOL_W | Volume code to write |
| soft_mute_req | input | 1 | Start a soft-mute ramp |
| cal_done | input | 1 | Offset calibration finished |
| vol_code | output | VOL_W | Effective volume code for both channels |
| out_connect | output | 1 | 1 connects output buffers, 0 terminates outputs to ground |
| cal_start | output | 1 | One-cycle offset-calibration request |
| wr_ignored | output | 1 | Register writes currently ignored |
| state_o | output | 3 | Controller state |

## Verification
The hardest situation to reach is the undervoltage recovery. The bench has to take the block through a hardware mute that undervoltage triggered, then satisfy the calibration while the flag is still high, and only then release the flag, so that the new power-on window can be told apart from an ordinary unmute. The stimulus gets there by raising the flag in ACTIVE, giving a coincident zero crossing, pulsing `cal_done` while the flag stays high, and then dropping it. It then raises the flag again inside the new window and inside the following calibration, to show the sequence restarts each time. The timeout path is measured by counting the pending cycles, with the bench's clock-rate parameter scaled down.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT  = 3'd0,
        ST_CALIBRATE = 3'd1,
        ST_ACTIVE    = 3'd2,
        ST_MUTE_PEND = 3'd3,
        ST_MUTED     = 3'd4,
        ST_SOFT_RAMP = 3'd5
    } amseq_state_e;

    // Output buffers are driven only in the states where audio may flow.
    function automatic logic drives_output(amseq_state_e st);
        return (st == ST_ACTIVE) || (st == ST_MUTE_PEND) || (st == ST_SOFT_RAMP);
    endfunction

endpackage

// File: rtl/amseq_timer.sv
// Saturating up-counter: expired once LIMIT cycles of run have elapsed since clr.
module amseq_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && !at_limit) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = at_limit;
endmodule

// File: rtl/amseq_steptick.sv
// Periodic tick while run is high; the phase restarts whenever run drops.
module amseq_steptick #(
    parameter int unsigned PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

    logic [CW-1:0] ph_d, ph_q;
    logic          wrap;

    assign wrap = (ph_q == CW'(PERIOD - 1));

    always_comb begin
        ph_d = ph_q;
        if (!run || wrap) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign tick = run && wrap;
endmodule

// File: rtl/audio_mute_seq.sv
module audio_mute_seq #(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned VOL_W    = 8,
    parameter int unsigned STEP_CYC = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mute_n,
    input  logic             zc_left,
    input  logic             zc_right,
    input  logic             uv_flag,
    input  logic             load_strobe,
    input  logic [VOL_W-1:0] load_code,
    input  logic             soft_mute_req,
    input  logic             cal_done,
    output logic [VOL_W-1:0] vol_code,
    output logic             out_connect,
    output logic             cal_start,
    output logic             wr_ignored,
    output logic [2:0]       state_o
);
    import amseq_pkg::*;

    // Window lengths in clock cycles: 18 ms disconnect timeout, 100 us write lockout.
    localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * 18;
    localparam int unsigned POR_RAW = CLK_HZ / 10000;
    localparam int unsigned POR_CYC = (POR_RAW < 1) ? 1 : POR_RAW;

    typedef struct packed {
        amseq_state_e     state;
        logic [VOL_W-1:0] vol;
        logic             cal_start;
        logic             cal_seen;
        logic             uv_lat;
    } ctl_t;

    ctl_t r_d, r_q;

    logic por_expired;
    logic tmo_expired;
    logic step_tick;
    logic both_zc;
    logic hw_mute;

    assign both_zc = zc_left && zc_right;
    assign hw_mute = !mute_n || uv_flag;

    amseq_timer #(.LIMIT(POR_CYC)) u_por_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((r_q.state != ST_POR_WAIT) || uv_flag),
        .run     (r_q.state == ST_POR_WAIT),
        .expired (por_expired)
    );

    amseq_timer #(.LIMIT(TMO_CYC)) u_mute_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (r_q.state != ST_MUTE_PEND),
        .run     (r_q.state == ST_MUTE_PEND),
        .expired (tmo_expired)
    );

    amseq_steptick #(.PERIOD(STEP_CYC)) u_ramp_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_SOFT_RAMP),
        .tick  (step_tick)
    );

    always_comb begin
        r_d           = r_q;
        r_d.cal_start = 1'b0;
        r_d.uv_lat    = r_q.uv_lat || uv_flag;
        if (cal_done) begin
            r_d.cal_seen = 1'b1;
        end

        unique case (r_q.state)
            ST_POR_WAIT: begin
                r_d.vol = '0;
                if (!uv_flag && por_expired) begin
                    r_d.state     = ST_CALIBRATE;
                    r_d.cal_start = 1'b1;
                end
            end
            ST_CALIBRATE: begin
                if (load_strobe) begin
                    r_d.vol = load_code;
                end
                if (uv_flag) begin
                    r_d.state = ST_POR_WAIT;
                    r_d.vol   = '0;
                end else if (r_q.cal_seen && mute_n) begin
                    r_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (load_strobe) begin
                    r_d.vol = load_code;
                end
                if (hw_mute) begin
                    r_d.state = ST_MUTE_PEND;
                end else if (!load_strobe && soft_mute_req && (r_q.vol != '0)) begin
                    r_d.state = ST_SOFT_RAMP;
                end
            end
            ST_SOFT_RAMP: begin
                if (load_strobe) begin
                    r_d.vol = load_code;
                end
                if (hw_mute) begin
                    r_d.state = ST_MUTE_PEND;
                end else if (load_strobe) begin
                    r_d.state = ST_ACTIVE;
                end else if (step_tick) begin
                    r_d.vol = r_q.vol - VOL_W'(1);
                    if (r_q.vol == VOL_W'(1)) begin
                        r_d.state = ST_ACTIVE;
                    end
                end
            end
            ST_MUTE_PEND: begin
                if (load_strobe) begin
                    r_d.vol = load_code;
                end
                if (both_zc || tmo_expired) begin
                    r_d.state     = ST_MUTED;
                    r_d.cal_start = 1'b1;
                end
            end
            ST_MUTED: begin
                if (load_strobe) begin
                    r_d.vol = load_code;
                end
                if (r_q.uv_lat && !uv_flag) begin
                    r_d.state = ST_POR_WAIT;
                    r_d.vol   = '0;
                end else if (!r_q.uv_lat && !uv_flag && mute_n && r_q.cal_seen) begin
                    r_d.state = ST_ACTIVE;
                end
            end
            default: begin
                r_d.state = ST_POR_WAIT;
                r_d.vol   = '0;
            end
        endcase

        if (r_d.cal_start) begin
            r_d.cal_seen = 1'b0;
        end
        if (r_d.state == ST_POR_WAIT) begin
            r_d.uv_lat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_POR_WAIT;
            r_q.vol       <= '0;
            r_q.cal_start <= 1'b0;
            r_q.cal_seen  <= 1'b0;
            r_q.uv_lat    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign vol_code    = r_q.vol;
    assign out_connect = drives_output(r_q.state);
    assign cal_start   = r_q.cal_start;
    assign wr_ignored  = (r_q.state == ST_POR_WAIT);
    assign state_o     = r_q.state;
endmodule

// File: rtl/amseq_checker.sv
module amseq_checker #(
    parameter int unsigned VOL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_strobe,
    input logic [VOL_W-1:0] load_code,
    input logic [VOL_W-1:0] vol_code,
    input logic             out_connect,
    input logic             cal_start,
    input logic             wr_ignored,
    input logic [2:0]       state_o
);
    // R1
    por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ignored |-> (vol_code == '0 && !out_connect));

    // R8
    cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R8
    disc_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_connect) |-> cal_start);

    // R6
    disc_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_connect) |-> ($past(state_o) == 3'd3));

    // R9
    reconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_connect) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd4));

    // R4
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && !load_strobe) |=>
            (vol_code == $past(vol_code) || vol_code == $past(vol_code) - VOL_W'(1)));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && load_strobe) |=> (vol_code == $past(load_code)));
endmodule

bind audio_mute_seq amseq_checker #(.VOL_W(VOL_W)) u_amseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_strobe (load_strobe),
    .load_code   (load_code),
    .vol_code    (vol_code),
    .out_connect (out_connect),
    .cal_start   (cal_start),
    .wr_ignored  (wr_ignored),
    .state_o     (state_o)
);

// File: tb/audio_mute_seq_test.sv
`timescale 1ns/1ps
module audio_mute_seq_test;
    localparam int unsigned CLK_HZ = 100_000;
    localparam int unsigned STEP   = 4;
    localparam int TMO  = CLK_HZ * 18 / 1000;
    localparam int PORW = CLK_HZ / 10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mute_n = 1'b1;
    logic       zc_left = 1'b0, zc_right = 1'b0;
    logic       uv_flag = 1'b0;
    logic       load_strobe = 1'b0;
    logic [7:0] load_code = 8'h00;
    logic       soft_mute_req = 1'b0;
    logic       cal_done = 1'b0;
    logic [7:0] vol_code;
    logic       out_connect, cal_start, wr_ignored;
    logic [2:0] state_o;

    audio_mute_seq #(.CLK_HZ(CLK_HZ), .VOL_W(8), .STEP_CYC(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .zc_left(zc_left),
        .zc_right(zc_right), .uv_flag(uv_flag), .load_strobe(load_strobe),
        .load_code(load_code), .soft_mute_req(soft_mute_req), .cal_done(cal_done),
        .vol_code(vol_code), .out_connect(out_connect), .cal_start(cal_start),
        .wr_ignored(wr_ignored), .state_o(state_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Reference model: behavioural, updated from the inputs at each rising edge.
    int  m_st = 0, m_vol = 0, m_por_age = 0, m_pend_age = 0, m_ramp_age = 0;
    bit  m_cs = 0, m_seen = 0, m_uvl = 0;

    always @(posedge clk) begin
        int  ns, nv, npa, npe, nra;
        bit  ncs, nseen, nuvl, hw;
        if (!rst_n) begin
            m_st = 0; m_vol = 0; m_por_age = 0; m_pend_age = 0; m_ramp_age = 0;
            m_cs = 0; m_seen = 0; m_uvl = 0;
        end else begin
            ns = m_st; nv = m_vol; ncs = 0; npa = 0; npe = 0; nra = 0;
            nseen = m_seen | cal_done;
            nuvl = m_uvl | uv_flag;
            hw = !mute_n || uv_flag;
            if (m_st == 0) begin
                nv = 0;
                if (uv_flag) npa = 0;
                else if (m_por_age >= PORW) begin ns = 1; ncs = 1; end
                else npa = m_por_age + 1;
            end else begin
                if (load_strobe) nv = load_code;
                case (m_st)
                    1: if (uv_flag) begin ns = 0; nv = 0; end
                       else if (m_seen && mute_n) ns = 2;
                    2: if (hw) ns = 3;
                       else if (!load_strobe && soft_mute_req && m_vol != 0) ns = 5;
                    5: begin
                        if (hw) ns = 3;
                        else if (load_strobe) ns = 2;
                        else begin
                            if ((m_ramp_age % STEP) == STEP - 1) begin
                                nv = m_vol - 1;
                                if (m_vol == 1) ns = 2;
                            end
                            nra = m_ramp_age + 1;
                        end
                        if (ns != 5) nra = 0;
                    end
                    3: if ((zc_left && zc_right) || m_pend_age >= TMO) begin ns = 4; ncs = 1; end
                       else npe = m_pend_age + 1;
                    4: if (m_uvl && !uv_flag) begin ns = 0; nv = 0; end
                       else if (!m_uvl && !uv_flag && mute_n && m_seen) ns = 2;
                    default: ;
                endcase
            end
            if (ncs) nseen = 0;
            if (ns == 0) nuvl = 0;
            if (ns != 0) npa = 0;
            m_st = ns; m_vol = nv & 8'hFF; m_cs = ncs; m_seen = nseen; m_uvl = nuvl;
            m_por_age = npa; m_pend_age = npe; m_ramp_age = nra;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(state_o == m_st[2:0], "R12 state", state_o, m_st);
            chk(vol_code == m_vol[7:0], "R3 vol_code", vol_code, m_vol);
            chk(out_connect == (m_st == 2 || m_st == 3 || m_st == 5), "R6 out_connect",
                out_connect, (m_st == 2 || m_st == 3 || m_st == 5));
            chk(cal_start == m_cs, "R8 cal_start", cal_start, m_cs);
            chk(wr_ignored == (m_st == 0), "R1 wr_ignored", wr_ignored, (m_st == 0));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input int target, input int limit);
        for (int i = 0; i < limit && state_o != target[2:0]; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] code);
        load_strobe = 1'b1; load_code = code;
        step(1);
        load_strobe = 1'b0;
    endtask

    task automatic pulse_cal();
        cal_done = 1'b1; step(1); cal_done = 1'b0;
    endtask

    task automatic pulse_soft();
        soft_mute_req = 1'b1; step(1); soft_mute_req = 1'b0;
    endtask

    initial begin
        int n;
        step(3);
        chk(state_o == 3'd0 && vol_code == 8'd0, "R1 reset state", state_o, 0);
        rst_n = 1'b1;
        step(1);
        do_load(8'h55);
        chk(wr_ignored == 1'b1, "R1 lockout flag", wr_ignored, 1);
        chk(vol_code == 8'h00, "R1 load ignored", vol_code, 0);
        wait_state(1, 100);
        chk(state_o == 3'd1, "R2 calibrate entered", state_o, 1);
        chk(cal_start == 1'b1, "R2 cal_start at calibrate", cal_start, 1);
        step(4);
        chk(state_o == 3'd1 && !out_connect, "R2 waits for cal_done", state_o, 1);
        pulse_cal();
        step(1);
        chk(state_o == 3'd2 && out_connect, "R2 active after cal", state_o, 2);

        do_load(8'h80);
        chk(vol_code == 8'h80, "R3 load", vol_code, 8'h80);
        do_load(8'h00);
        chk(vol_code == 8'h00 && out_connect, "R3 software mute stays connected", vol_code, 0);

        do_load(8'h06);
        pulse_soft();
        chk(state_o == 3'd5, "R4 ramp entered", state_o, 5);
        step(STEP);
        chk(vol_code == 8'h05, "R4 first step", vol_code, 5);
        step(6 * STEP);
        chk(vol_code == 8'h00 && state_o == 3'd2, "R4 ramp ends at zero", vol_code, 0);
        pulse_soft();
        chk(state_o == 3'd2, "R4 request at zero ignored", state_o, 2);

        do_load(8'h40);
        pulse_soft();
        step(2 * STEP);
        do_load(8'h30);
        chk(vol_code == 8'h30 && state_o == 3'd2, "R5 ramp aborted by load", vol_code, 8'h30);

        mute_n = 1'b0;
        step(1);
        chk(state_o == 3'd3 && out_connect, "R6 pending stays connected", state_o, 3);
        zc_left = 1'b1;
        step(3);
        chk(state_o == 3'd3, "R6 one channel crossing ignored", state_o, 3);
        zc_right = 1'b1;
        step(1);
        zc_left = 1'b0; zc_right = 1'b0;
        chk(state_o == 3'd4 && !out_connect, "R6 disconnect on joint crossing", state_o, 4);
        chk(cal_start == 1'b1, "R8 calibration on mute", cal_start, 1);
        mute_n = 1'b1;
        step(5);
        chk(state_o == 3'd4, "R9 held until cal_done", state_o, 4);
        do_load(8'h22);
        chk(vol_code == 8'h22 && !out_connect, "R9 load while muted", vol_code, 8'h22);
        pulse_cal();
        step(1);
        chk(state_o == 3'd2 && vol_code == 8'h22, "R9 unmute after cal", state_o, 2);

        mute_n = 1'b0;
        step(1);
        n = 0;
        while (state_o == 3'd3 && n < 5000) begin n++; step(1); end
        chk(n == TMO + 1, "R7 timeout length", n, TMO + 1);
        mute_n = 1'b1;
        pulse_cal();
        step(1);
        chk(state_o == 3'd2, "R9 unmute after timeout mute", state_o, 2);

        uv_flag = 1'b1;
        step(1);
        chk(state_o == 3'd3, "R10 undervoltage starts mute", state_o, 3);
        zc_left = 1'b1; zc_right = 1'b1;
        step(1);
        zc_left = 1'b0; zc_right = 1'b0;
        chk(state_o == 3'd4, "R10 undervoltage muted", state_o, 4);
        pulse_cal();
        step(3);
        chk(state_o == 3'd4, "R10 held while supply low", state_o, 4);
        uv_flag = 1'b0;
        step(1);
        chk(state_o == 3'd0 && vol_code == 8'd0, "R10 recovery replays power-up", state_o, 0);
        uv_flag = 1'b1;
        step(30);
        chk(state_o == 3'd0, "R11 window held by undervoltage", state_o, 0);
        uv_flag = 1'b0;
        wait_state(1, 100);
        uv_flag = 1'b1;
        step(1);
        chk(state_o == 3'd0, "R11 undervoltage aborts calibration", state_o, 0);
        uv_flag = 1'b0;
        wait_state(1, 100);
        mute_n = 1'b0;
        pulse_cal();
        step(3);
        chk(state_o == 3'd1, "R2 pin low keeps calibrate", state_o, 1);
        mute_n = 1'b1;
        step(2);
        chk(state_o == 3'd2, "R2 active after pin release", state_o, 2);

        step(2);
        finish_run();
    end
endmodule